// File: doc/BRIEF.md
# Multiplexed MCU Host Bus Master

This block acts as the host on a classic multiplexed 8-bit microcontroller external bus, so that a command source inside the chip can read and write a memory-mapped peripheral. A command carries a 3-bit operation code, a 16-bit address and, for writes, a data byte. The block then runs one complete bus cycle. First an address phase drives the low address byte on the shared AD lines while ALE is high. A data phase follows with the chip select active and a read or write strobe. Read data comes back on `rd_data`, and a one-cycle `done` strobe marks the end of every operation.

The upper address byte sits in an output register that only the extended variants of read and write reload. A plain access therefore reaches a peripheral in the page set by the last extended access. The strobe phase lasts a fixed number of cycles and is stretched while the peripheral holds its ready input low. Two further operations wait until an interrupt-style input reaches a chosen level, so that a following read can be gated on that condition. Both the ready input and the wait input pass through two-flop synchronizers.

Top module: `mcu_bus_master`

## Requirements
- R1: After reset, and whenever no operation is running, `ale`=0, `cs_n`=`rd_n`=`wr_n`=1, `ad_oe`=0 and `busy`=0. After reset `addr_hi`=0x00.
- R2: When `busy`=0, a command is accepted on a clock edge with `cmd_valid`=1. The codes are 0 read, 1 read extended, 2 write, 3 write extended, 4 wait pin high and 5 wait pin low. `busy` is 1 from the next cycle until the operation ends. Commands presented while `busy`=1 are ignored, and codes 6 and 7 are ignored.
- R3: Each bus cycle begins with `ale` high for ALE_W (2) cycles, with `ad_out`=address[7:0] and `ad_oe`=1. `cs_n` is never low while `ale` is high.
- R4: `addr_hi` takes address[15:8] only when codes 1 or 3 are accepted. Codes 0 and 2 leave it unchanged.
- R5: A read holds `ad_oe`=0 from the end of ALE through the end of the cycle. It drives `rd_n` low for STRB_W (3) cycles when ready is high, and returns on `rd_data` the `ad_in` value sampled in the last strobe cycle.
- R6: A write drives the data byte on `ad_out` with `ad_oe`=1 before `wr_n` falls. It keeps `wr_n` low for STRB_W (3) cycles when ready is high, and still holds the same byte on the cycle `wr_n` rises.
- R7: While the synchronized `iordy` is low, the strobe stays active. If `iordy` rises after the minimum width has passed, the strobe ends 2 cycles after the synchronized level would first allow it.
- R8: Code 4 completes once the synchronized `wait_pin` is 1, and code 5 once it is 0. `done` appears on the third cycle after the pin changes.
- R9: `done` is a single-cycle pulse, issued in the cycle that `busy` returns to 0, once per accepted operation.
- R10: `rd_n` and `wr_n` are never low at the same time, and `cs_n` is low throughout every strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Operation code |
| cmd_addr | input | 16 | Bus address |
| cmd_wdata | input | 8 | Write data byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |
| rd_data | output | 8 | Last read data byte |
| ad_out | output | 8 | Multiplexed address/data output value |
| ad_oe | output | 1 | Output enable for the AD lines |
| ad_in | input | 8 | AD lines as seen from the pins |
| addr_hi | output | 8 | Registered upper address byte |
| ale | output | 1 | Address latch enable, active high |
| cs_n | output | 1 | Chip select, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| iordy | input | 1 | Peripheral ready; low stretches the strobe |
| wait_pin | input | 1 | Level input watched by the wait operations |

## Verification
A sequence mixes plain and extended reads and writes across different pages. It shows that the upper byte follows only the extended codes, and that a plain access lands at the combination of the held page and the new low byte. A peripheral model latches the address on the falling edge of ALE and answers reads with an address-dependent byte, so a wrong latch, a wrong page or a wrong sample cycle each gives a different byte. The directed cases cover a ready line held low, which shows the exact strobe stretch. They also cover a command issued mid-cycle and an unused code, which show that ignored commands produce no strobe and no page change, and both wait polarities, whose completion latency shows the synchronizer depth.

// File: rtl/mcu_bus_pkg.sv
// Package: shared operation codes and sequencer states for the host bus master.
// Assumes: op bit 0 selects the extended variant, op bit 1 selects a write.
package mcu_bus_pkg;
    typedef enum logic [2:0] {
        OP_RD     = 3'd0,
        OP_RD_EXT = 3'd1,
        OP_WR     = 3'd2,
        OP_WR_EXT = 3'd3,
        OP_WAIT_H = 3'd4,
        OP_WAIT_L = 3'd5
    } bus_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_GAP,
        ST_STRB,
        ST_HOLD,
        ST_WAITP
    } bus_state_e;
endpackage

// File: rtl/mcu_bus_sync.sv
// Module: two-flop level synchronizer, one chain per bit.
// Assumes: inputs are slow levels; the reset value is 0 for every bit.
module mcu_bus_sync #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic meta;
        // Two-stage capture of one asynchronous bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta    <= 1'b0;
                dout[i] <= 1'b0;
            end else begin
                meta    <= din[i];
                dout[i] <= meta;
            end
        end
    end
endmodule

// File: rtl/mcu_bus_seq.sv
// Module: bus cycle sequencer. Runs address, gap, strobe and hold phases, or a pin wait.
// Assumes: every phase width parameter is at least 1, and ready and pin inputs are already synchronized.
module mcu_bus_seq
    import mcu_bus_pkg::*;
#(
    parameter int ALE_W  = 2,
    parameter int GAP_W  = 1,
    parameter int STRB_W = 3,
    parameter int HOLD_W = 1,
    parameter int AW     = 16,
    parameter int DW     = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_op,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_wdata,
    input  logic [DW-1:0] ad_in,
    input  logic          ready_s,
    input  logic          pin_s,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] rd_data,
    output logic [DW-1:0] ad_out,
    output logic          ad_oe,
    output logic [AW-DW-1:0] addr_hi,
    output logic          ale,
    output logic          cs_n,
    output logic          rd_n,
    output logic          wr_n
);
    localparam int CW = $clog2(ALE_W + GAP_W + STRB_W + HOLD_W + 1);
    localparam logic [CW-1:0] ALE_LAST  = CW'(ALE_W - 1);
    localparam logic [CW-1:0] GAP_LAST  = CW'(GAP_W - 1);
    localparam logic [CW-1:0] STRB_LAST = CW'(STRB_W - 1);
    localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_W - 1);

    bus_state_e    state;
    logic [CW-1:0] cnt;
    logic [DW-1:0] addr_lo;
    logic [DW-1:0] wdata;
    logic          is_wr;
    logic          want_lvl;
    logic          data_ph;

    // Phase sequencing, command capture, read sampling and upper-address update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            done     <= 1'b0;
            rd_data  <= '0;
            addr_lo  <= '0;
            wdata    <= '0;
            is_wr    <= 1'b0;
            want_lvl <= 1'b0;
            addr_hi  <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    if (cmd_valid) begin
                        if (cmd_op <= 3'd3) begin
                            state   <= ST_ADDR;
                            addr_lo <= cmd_addr[DW-1:0];
                            wdata   <= cmd_wdata;
                            is_wr   <= cmd_op[1];
                            if (cmd_op[0]) addr_hi <= cmd_addr[AW-1:DW];
                        end else if (cmd_op == OP_WAIT_H || cmd_op == OP_WAIT_L) begin
                            state    <= ST_WAITP;
                            want_lvl <= (cmd_op == OP_WAIT_H);
                        end
                    end
                end
                ST_ADDR: begin
                    if (cnt == ALE_LAST) begin
                        state <= ST_GAP;
                        cnt   <= '0;
                    end else cnt <= cnt + 1'b1;
                end
                ST_GAP: begin
                    if (cnt == GAP_LAST) begin
                        state <= ST_STRB;
                        cnt   <= '0;
                    end else cnt <= cnt + 1'b1;
                end
                ST_STRB: begin
                    if (cnt >= STRB_LAST) begin
                        if (ready_s) begin
                            if (!is_wr) rd_data <= ad_in;
                            state <= ST_HOLD;
                            cnt   <= '0;
                        end
                    end else cnt <= cnt + 1'b1;
                end
                ST_HOLD: begin
                    if (cnt == HOLD_LAST) begin
                        state <= ST_IDLE;
                        cnt   <= '0;
                        done  <= 1'b1;
                    end else cnt <= cnt + 1'b1;
                end
                ST_WAITP: begin
                    if (pin_s == want_lvl) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Bus pin decode from the registered phase.
    always_comb begin
        data_ph = (state == ST_GAP) || (state == ST_STRB) || (state == ST_HOLD);
        busy    = (state != ST_IDLE);
        ale     = (state == ST_ADDR);
        cs_n    = !data_ph;
        rd_n    = !((state == ST_STRB) && !is_wr);
        wr_n    = !((state == ST_STRB) && is_wr);
        ad_oe   = (state == ST_ADDR) || (data_ph && is_wr);
        ad_out  = (state == ST_ADDR) ? addr_lo : wdata;
    end
endmodule

// File: rtl/mcu_bus_master.sv
// Module: top of the multiplexed host bus master: synchronizers plus sequencer.
// Assumes: the pad ring applies ad_oe to the AD drivers and returns the pin levels on ad_in.
module mcu_bus_master #(
    parameter int ALE_W  = 2,
    parameter int GAP_W  = 1,
    parameter int STRB_W = 3,
    parameter int HOLD_W = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic [2:0]  cmd_op,
    input  logic [15:0] cmd_addr,
    input  logic [7:0]  cmd_wdata,
    output logic        busy,
    output logic        done,
    output logic [7:0]  rd_data,
    output logic [7:0]  ad_out,
    output logic        ad_oe,
    input  logic [7:0]  ad_in,
    output logic [7:0]  addr_hi,
    output logic        ale,
    output logic        cs_n,
    output logic        rd_n,
    output logic        wr_n,
    input  logic        iordy,
    input  logic        wait_pin
);
    logic [1:0] sync_q;
    logic       iordy_s;
    logic       pin_s;

    mcu_bus_sync #(.WIDTH(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({wait_pin, iordy}),
        .dout  (sync_q)
    );

    assign iordy_s = sync_q[0];
    assign pin_s   = sync_q[1];

    mcu_bus_seq #(
        .ALE_W (ALE_W), .GAP_W (GAP_W), .STRB_W (STRB_W), .HOLD_W (HOLD_W),
        .AW (16), .DW (8)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_addr  (cmd_addr),
        .cmd_wdata (cmd_wdata),
        .ad_in     (ad_in),
        .ready_s   (iordy_s),
        .pin_s     (pin_s),
        .busy      (busy),
        .done      (done),
        .rd_data   (rd_data),
        .ad_out    (ad_out),
        .ad_oe     (ad_oe),
        .addr_hi   (addr_hi),
        .ale       (ale),
        .cs_n      (cs_n),
        .rd_n      (rd_n),
        .wr_n      (wr_n)
    );
endmodule

// File: rtl/mcu_bus_master_chk.sv
// Module: protocol checker for mcu_bus_master, attached by bind.
// Assumes: it sees the top ports plus the synchronized ready level.
module mcu_bus_master_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [2:0] cmd_op,
    input logic       busy,
    input logic       done,
    input logic       ale,
    input logic       cs_n,
    input logic       rd_n,
    input logic       wr_n,
    input logic       ad_oe,
    input logic [7:0] ad_out,
    input logic [7:0] addr_hi,
    input logic       iordy_s
);
    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(!rd_n && !wr_n));
    // R10
    strobe_cs_chk: assert property (@(posedge clk) disable iff (!rst_n) (!rd_n || !wr_n) |-> !cs_n);
    // R5
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n) !rd_n |-> !ad_oe);
    // R3
    ale_cs_chk: assert property (@(posedge clk) disable iff (!rst_n) ale |-> cs_n);
    // R4
    page_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(addr_hi) |-> $past(cmd_valid && !busy && (cmd_op == 3'd1 || cmd_op == 3'd3)));
    // R7
    ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rd_n) || $rose(wr_n)) |-> $past(iordy_s));
    // R6
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_n) |-> (ad_oe && $stable(ad_out)));
    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
    // R9
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done);
    // R2
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && cmd_op <= 3'd5) |=> busy);
    // R1
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!ale && cs_n && rd_n && wr_n && !ad_oe));
endmodule

bind mcu_bus_master mcu_bus_master_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .busy      (busy),
    .done      (done),
    .ale       (ale),
    .cs_n      (cs_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .ad_oe     (ad_oe),
    .ad_out    (ad_out),
    .addr_hi   (addr_hi),
    .iordy_s   (iordy_s)
);

// File: tb/mcu_bus_master_test.sv
// Bench: vector loop over reads and writes, then directed reset, blocking, ready and wait cases.
module mcu_bus_master_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [15:0] cmd_addr = 16'h0;
    logic [7:0]  cmd_wdata = 8'h0;
    logic        busy, done, ad_oe, ale, cs_n, rd_n, wr_n;
    logic [7:0]  rd_data, ad_out, ad_in, addr_hi;
    logic        iordy = 1'b1;
    logic        wait_pin = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    mcu_bus_master uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .busy(busy), .done(done),
        .rd_data(rd_data), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
        .addr_hi(addr_hi), .ale(ale), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .iordy(iordy), .wait_pin(wait_pin)
    );

    function automatic logic [7:0] rdfun(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    // Peripheral model state, updated on the falling clock edge.
    logic [7:0]  lat_lo = 8'h0;
    logic        p_ale = 0, p_rd = 1, p_wr = 1;
    logic [7:0]  p_ad = 8'h0;
    int ale_run = 0, ale_w = 0, rd_run = 0, rd_w = 0, wr_run = 0, wr_w = 0;
    int done_cnt = 0, wr_falls = 0, cont_err = 0, both_low = 0;
    logic [15:0] wr_addr = 16'h0;
    logic [7:0]  wr_data = 8'h0;
    bit wr_setup_ok = 0, wr_hold_ok = 0;
    logic [7:0] exp_wdata = 8'h0;

    assign ad_in = !rd_n ? rdfun({addr_hi, lat_lo}) : 8'h00;

    always @(negedge clk) begin
        if (ale) begin ale_run++; lat_lo <= ad_out; end
        if (p_ale && !ale) begin ale_w = ale_run; ale_run = 0; end
        if (!rd_n) rd_run++;
        if (!p_rd && rd_n) begin rd_w = rd_run; rd_run = 0; end
        if (!wr_n) wr_run++;
        if (p_wr && !wr_n) begin
            wr_falls++;
            wr_setup_ok = ad_oe && (ad_out == exp_wdata);
        end
        if (!p_wr && wr_n) begin
            wr_w = wr_run; wr_run = 0;
            wr_hold_ok = ad_oe && (ad_out == p_ad);
            wr_addr = {addr_hi, lat_lo};
            wr_data = p_ad;
        end
        if (!rd_n && ad_oe) cont_err++;
        if (!rd_n && !wr_n) both_low++;
        if ((!rd_n || !wr_n) && cs_n) both_low++;
        if (done) done_cnt++;
        p_ale = ale; p_rd = rd_n; p_wr = wr_n; p_ad = ad_out;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] op, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = d; exp_wdata = d;
        done_cnt = 0; wr_setup_ok = 0; wr_hold_ok = 0;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_done(output int n);
        n = 0;
        while (!done && n < 200) begin @(negedge clk); n++; end
        if (n >= 200) check(0, "R9 timeout", n, 0);
        repeat (3) @(negedge clk);
    endtask

    // op, address, write data, expected upper byte afterwards
    localparam logic [34:0] VEC [6] = '{
        {3'd3, 16'h1234, 8'hA5, 8'h12},
        {3'd0, 16'hFF56, 8'h00, 8'h12},
        {3'd2, 16'h0078, 8'h3C, 8'h12},
        {3'd1, 16'hAB01, 8'h00, 8'hAB},
        {3'd2, 16'h00FE, 8'h00, 8'hAB},
        {3'd1, 16'h0000, 8'h00, 8'h00}
    };

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R1 reset levels
        check(!ale && cs_n && rd_n && wr_n && !ad_oe && !busy, "R1 idle levels in reset",
              {ale, cs_n, rd_n, wr_n, ad_oe, busy}, 6'b011100);
        rst_n = 1'b1;
        @(negedge clk);
        check(addr_hi == 8'h00 && !busy, "R1 addr_hi after reset", addr_hi, 0);

        foreach (VEC[i]) begin
            logic [2:0]  op;
            logic [15:0] a;
            logic [7:0]  d, eh;
            {op, a, d, eh} = VEC[i];
            issue(op, a, d);
            check(busy, "R2 busy after accept", busy, 1);
            wait_done(n);
            check(done_cnt == 1, "R9 single done pulse", done_cnt, 1);
            check(addr_hi == eh, "R4 upper address", addr_hi, eh);
            check(ale_w == 2 && lat_lo == a[7:0], "R3 ALE width and low address",
                  {ale_w[7:0], lat_lo}, {8'd2, a[7:0]});
            check(!ale && cs_n && rd_n && wr_n && !ad_oe && !busy, "R1 idle after op",
                  {ale, cs_n, rd_n, wr_n, ad_oe, busy}, 6'b011100);
            if (op[1]) begin
                check(wr_w == 3, "R6 write strobe width", wr_w, 3);
                check(wr_setup_ok && wr_hold_ok, "R6 data setup and hold",
                      {wr_setup_ok, wr_hold_ok}, 2'b11);
                check(wr_addr == {eh, a[7:0]} && wr_data == d, "R6 write landed",
                      {wr_addr, wr_data}, {eh, a[7:0], d});
            end else begin
                check(rd_w == 3, "R5 read strobe width", rd_w, 3);
                check(rd_data == rdfun({eh, a[7:0]}), "R5 read data", rd_data, rdfun({eh, a[7:0]}));
            end
        end
        check(cont_err == 0, "R5 no bus contention", cont_err, 0);

        // R2 command during busy is ignored
        begin
            int wf;
            wf = wr_falls;
            issue(3'd2, 16'h0010, 8'h77);
            @(negedge clk);
            cmd_valid = 1'b1; cmd_op = 3'd3; cmd_addr = 16'h9900; cmd_wdata = 8'h11;
            @(negedge clk);
            cmd_valid = 1'b0;
            wait_done(n);
            repeat (20) @(negedge clk);
            check(addr_hi == 8'h00, "R2 busy command did not change page", addr_hi, 0);
            check(wr_falls - wf == 1 && wr_data == 8'h77, "R2 busy command produced no cycle",
                  wr_falls - wf, 1);
        end

        // R2 unused code is ignored
        issue(3'd7, 16'hC3C3, 8'h00);
        check(!busy && !ale, "R2 code 7 ignored", busy, 0);
        repeat (5) @(negedge clk);
        check(done_cnt == 0 && addr_hi == 8'h00, "R2 code 7 no done", done_cnt, 0);

        // R7 ready held low stretches the strobe
        iordy = 1'b0;
        issue(3'd0, 16'h0042, 8'h00);
        n = 0;
        while (rd_n && n < 50) begin @(negedge clk); n++; end
        repeat (4) @(negedge clk);
        iordy = 1'b1;
        wait_done(n);
        check(rd_w == 7, "R7 stretched strobe width", rd_w, 7);
        check(rd_data == rdfun(16'h0042), "R7 read data after stretch", rd_data, rdfun(16'h0042));

        // R8 wait until pin high
        wait_pin = 1'b0;
        repeat (3) @(negedge clk);
        issue(3'd4, 16'h0, 8'h0);
        repeat (10) @(negedge clk);
        check(busy && done_cnt == 0, "R8 wait high still pending", busy, 1);
        wait_pin = 1'b1;
        n = 0;
        while (!done && n < 50) begin @(negedge clk); n++; end
        check(n == 3, "R8 wait high latency", n, 3);
        // R8 wait until pin low
        issue(3'd5, 16'h0, 8'h0);
        repeat (10) @(negedge clk);
        check(busy && done_cnt == 0, "R8 wait low still pending", busy, 1);
        wait_pin = 1'b0;
        n = 0;
        while (!done && n < 50) begin @(negedge clk); n++; end
        check(n == 3, "R8 wait low latency", n, 3);
        repeat (3) @(negedge clk);
        check(!busy, "R8 idle after wait", busy, 0);

        check(both_low == 0, "R10 strobe exclusivity and chip select", both_low, 0);

        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // Watchdog: ends a hung run as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule